// File: doc/BRIEF.md
# Outstanding transaction tracker with aging

This block keeps a small table of bus transactions that a host controller's schedule engine has issued and that are still in flight. Each entry holds the descriptor address the transaction came from, the full 32-bit token it was issued with, a signed age counter and a completion flag. When the schedule walker meets an active descriptor, it first looks the pair up. A miss means the walker issues the transaction and allocates an entry. A hit on an entry that is still running tells the walker to skip the descriptor. A hit on a completed entry hands the entry back for completion processing and frees it.

An entry only lives while the schedule keeps visiting it. Every start of frame ages all live entries by one step. A lookup hit, or a fresh allocation, reloads the age. A descriptor that is seen again with a different token has its old entry expired at once. At the end of a frame a walker visits the entries one per clock cycle. It removes every entry whose age has run out and emits a cancel request for each removed entry that never completed. A cancel-all request runs the same walk but treats every live entry as expired, which serves the controller's reset.

Top module: `xfer_tracker`

## Requirements
- R1: After reset the table is empty: every lookup misses, `allocOk` is 1 with `allocIdx` 0, and `cancelValid` and `sweepDone` are 0.
- R2: A lookup hits only when both the stored address and the full stored token equal the request. `lookupHit` and `lookupIdx` are combinational in the request cycle. A hit on an entry that has not completed leaves `lookupDone` at 0 and keeps the entry.
- R3: A lookup whose address matches a live entry but whose token differs reports a miss and forces that entry's age to zero if it was positive, so the next end-of-frame walk removes it.
- R4: An allocation or a lookup hit loads the entry's age with the reload value (default 10).
- R5: Each `frameStart` cycle lowers the age of every live entry by one, saturating at the most negative value. The end-of-frame walk removes an entry whose age is zero or negative. An entry allocated and never revisited therefore survives 9 frame starts but not 10.
- R6: A `frameEnd` sampled at a clock edge starts a walk that visits entries 0 to ENTRIES-1 in ascending order, one per cycle, from the next cycle on. When the visited entry is removed and has not completed, `cancelValid` is high in that visit cycle with that entry's index, address and token. `sweepDone` is high in the cycle that visits the last index.
- R7: A lookup hit on a completed entry raises `lookupDone` in the same cycle and frees the entry, so a repeat of the same lookup misses.
- R8: `completeValid` with `completeIdx` sets the done flag of that live entry at the clock edge, and later lookups of it report `lookupDone`.
- R9: `cancelAll` starts (or restarts) a walk from index 0 in which every live entry is removed, with a cancel request for each one not completed. The table ends empty.
- R10: Allocation takes the lowest free index. With every entry live, `allocOk` is 0 and an allocation request changes no entry.
- R11: A completion for the entry visited by a walk in that same cycle suppresses its cancel request, and the entry is still removed.
- R12: A lookup hit in the same cycle as `frameStart` leaves the entry at the full reload age (the refresh wins over the decrement).
- R13: A `frameEnd` that arrives while a walk is running is ignored: no second walk and no second `sweepDone` follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStart | input | 1 | Age step for all live entries |
| frameEnd | input | 1 | Starts the end-of-frame walk |
| cancelAll | input | 1 | Starts a walk that removes every entry |
| lookupValid | input | 1 | Lookup request |
| lookupAddr | input | ADDR_W | Descriptor address to look up |
| lookupToken | input | TOKEN_W | Token to look up |
| lookupHit | output | 1 | Address and token both matched |
| lookupDone | output | 1 | The matched entry has completed and is being freed |
| lookupIdx | output | IDX_W | Index of the matched entry |
| allocValid | input | 1 | Allocate an entry for a newly issued transaction |
| allocAddr | input | ADDR_W | Address stored on allocation |
| allocToken | input | TOKEN_W | Token stored on allocation |
| allocOk | output | 1 | A free entry exists |
| allocIdx | output | IDX_W | Lowest free entry index |
| completeValid | input | 1 | Device completion |
| completeIdx | input | IDX_W | Entry that completed |
| cancelValid | output | 1 | Cancel request for the visited entry |
| cancelIdx | output | IDX_W | Index of the entry to cancel |
| cancelAddr | output | ADDR_W | Address of the entry to cancel |
| cancelToken | output | TOKEN_W | Token of the entry to cancel |
| sweepDone | output | 1 | Walk is visiting its last entry |

## Verification
The risky overlap is a device completion that lands in the very cycle the walker visits the same entry. The bench starts a cancel-all walk and drives `completeValid` for entry 5 exactly in the cycle whose visit index is 5. It expects a cancel for every live entry except that one and the one that had already completed, and both entries gone afterwards. A second overlap, a lookup refresh in the same cycle as an age step, is judged by counting further frame starts until the refreshed entry is expected to expire.

// File: rtl/xt_pkg.sv
package xt_pkg;

  // Strobes from the walk control to the entry datapath.
  typedef struct packed {
    logic visit;   // an entry is visited this cycle
    logic flush;   // visited entry is removed regardless of age
  } walkStrobeT;

endpackage

// File: rtl/xt_ctrl.sv
module xt_ctrl #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameEnd,
  input  logic                 cancelAll,
  output xt_pkg::walkStrobeT   strobe,
  output logic [IDX_W-1:0]     walkIdx,
  output logic                 sweepDone
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic             busy;
  logic             flushQ;
  logic [IDX_W-1:0] ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      flushQ <= 1'b0;
      ptr    <= '0;
    end else if (cancelAll) begin
      busy   <= 1'b1;
      flushQ <= 1'b1;
      ptr    <= '0;
    end else if (busy) begin
      if (ptr == LAST_IDX) begin
        busy   <= 1'b0;
        flushQ <= 1'b0;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end else if (frameEnd) begin
      busy   <= 1'b1;
      flushQ <= 1'b0;
      ptr    <= '0;
    end
  end

  always_comb begin
    strobe.visit = busy;
    strobe.flush = flushQ;
  end

  assign walkIdx   = ptr;
  assign sweepDone = busy && (ptr == LAST_IDX);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sweepDone |=> !sweepDone); // R6

  AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && !sweepDone && !cancelAll) |=> (strobe.visit && walkIdx == $past(walkIdx) + 1'b1)); // R6

  AST_FRAME_END_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && !sweepDone && !cancelAll && frameEnd) |=> (walkIdx != '0)); // R13

  AST_FLUSH_START: assert property (@(posedge clk) disable iff (!rstN)
    cancelAll |=> (strobe.visit && strobe.flush && walkIdx == '0)); // R9

endmodule

// File: rtl/xt_table.sv
module xt_table #(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned TOKEN_W    = 32,
  parameter int unsigned AGE_W      = 8,
  parameter int unsigned AGE_RELOAD = 10,
  parameter int unsigned IDX_W      = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xt_pkg::walkStrobeT   strobe,
  input  logic [IDX_W-1:0]     walkIdx,
  input  logic                 frameStart,
  input  logic                 lookupValid,
  input  logic [ADDR_W-1:0]    lookupAddr,
  input  logic [TOKEN_W-1:0]   lookupToken,
  output logic                 lookupHit,
  output logic                 lookupDone,
  output logic [IDX_W-1:0]     lookupIdx,
  input  logic                 allocValid,
  input  logic [ADDR_W-1:0]    allocAddr,
  input  logic [TOKEN_W-1:0]   allocToken,
  output logic                 allocOk,
  output logic [IDX_W-1:0]     allocIdx,
  input  logic                 completeValid,
  input  logic [IDX_W-1:0]     completeIdx,
  output logic                 cancelValid,
  output logic [IDX_W-1:0]     cancelIdx,
  output logic [ADDR_W-1:0]    cancelAddr,
  output logic [TOKEN_W-1:0]   cancelToken
);

  localparam logic signed [AGE_W-1:0] AGE_FULL = AGE_W'(AGE_RELOAD);
  localparam logic signed [AGE_W-1:0] AGE_MIN  = {1'b1, {(AGE_W-1){1'b0}}};

  logic [ENTRIES-1:0] live;
  logic [ENTRIES-1:0] doneFlag;
  logic [ENTRIES-1:0] here;
  logic [ENTRIES-1:0] stale;
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] missVec;
  logic [ENTRIES-1:0] retire;
  logic [ENTRIES-1:0] takeSlot;
  logic [ENTRIES-1:0] doneIn;
  logic [ADDR_W-1:0]  addrArr [ENTRIES];
  logic [TOKEN_W-1:0] tokArr  [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic                     liveQ;
    logic                     doneQ;
    logic [ADDR_W-1:0]        addrR;
    logic [TOKEN_W-1:0]       tokR;
    logic signed [AGE_W-1:0]  ageR;
    logic                     addrEq;
    logic                     expired;

    assign live[i]     = liveQ;
    assign doneFlag[i] = doneQ;
    assign addrArr[i]  = addrR;
    assign tokArr[i]   = tokR;

    assign expired     = ageR[AGE_W-1] || (ageR == '0);
    assign here[i]     = strobe.visit && (walkIdx == IDX_W'(i));
    assign stale[i]    = liveQ && here[i] && (strobe.flush || expired);
    assign addrEq      = lookupValid && liveQ && !stale[i] && (addrR == lookupAddr);
    assign hitVec[i]   = addrEq && (tokR == lookupToken);
    assign missVec[i]  = addrEq && (tokR != lookupToken);
    assign retire[i]   = hitVec[i] && doneQ;
    assign takeSlot[i] = allocValid && allocOk && (allocIdx == IDX_W'(i));
    assign doneIn[i]   = completeValid && (completeIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        liveQ <= 1'b0;
        doneQ <= 1'b0;
        addrR <= '0;
        tokR  <= '0;
        ageR  <= '0;
      end else if (stale[i] || retire[i]) begin
        liveQ <= 1'b0;
        doneQ <= 1'b0;
      end else if (takeSlot[i]) begin
        liveQ <= 1'b1;
        doneQ <= 1'b0;
        addrR <= allocAddr;
        tokR  <= allocToken;
        ageR  <= AGE_FULL;
      end else if (liveQ) begin
        if (doneIn[i]) doneQ <= 1'b1;
        if (hitVec[i]) begin
          ageR <= AGE_FULL;
        end else if (missVec[i]) begin
          if (!ageR[AGE_W-1] && ageR != '0) ageR <= '0;
        end else if (frameStart && ageR != AGE_MIN) begin
          ageR <= ageR - 1'b1;
        end
      end
    end
  end

  // Lowest-index encoders for lookup result and free slot.
  always_comb begin
    lookupIdx = '0;
    allocIdx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) lookupIdx = IDX_W'(i);
      if (!live[i])  allocIdx  = IDX_W'(i);
    end
  end

  always_comb begin
    lookupDone = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookupIdx == IDX_W'(i)) lookupDone = hitVec[i] && doneFlag[i];
    end
  end

  assign lookupHit = |hitVec;
  assign allocOk   = ~&live;

  // Cancel request for the entry under the walker.
  always_comb begin
    cancelValid = 1'b0;
    cancelAddr  = '0;
    cancelToken = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (stale[i] && !doneFlag[i] && !doneIn[i]) begin
        cancelValid = 1'b1;
        cancelAddr  = addrArr[i];
        cancelToken = tokArr[i];
      end
    end
  end

  assign cancelIdx = walkIdx;

  AST_CANCEL_FREES: assert property (@(posedge clk) disable iff (!rstN)
    cancelValid |=> !live[$past(walkIdx)]); // R6

  AST_RETIRE_FREES: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && lookupDone) |=> !live[$past(lookupIdx)]); // R7

  AST_ALLOC_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocOk) |=> live[$past(allocIdx)]); // R10

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.visit && strobe.flush) |=> !live[$past(walkIdx)]); // R9

endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned TOKEN_W    = 32,
  parameter int unsigned AGE_W      = 8,
  parameter int unsigned AGE_RELOAD = 10,
  localparam int unsigned IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic               frameEnd,
  input  logic               cancelAll,
  input  logic               lookupValid,
  input  logic [ADDR_W-1:0]  lookupAddr,
  input  logic [TOKEN_W-1:0] lookupToken,
  output logic               lookupHit,
  output logic               lookupDone,
  output logic [IDX_W-1:0]   lookupIdx,
  input  logic               allocValid,
  input  logic [ADDR_W-1:0]  allocAddr,
  input  logic [TOKEN_W-1:0] allocToken,
  output logic               allocOk,
  output logic [IDX_W-1:0]   allocIdx,
  input  logic               completeValid,
  input  logic [IDX_W-1:0]   completeIdx,
  output logic               cancelValid,
  output logic [IDX_W-1:0]   cancelIdx,
  output logic [ADDR_W-1:0]  cancelAddr,
  output logic [TOKEN_W-1:0] cancelToken,
  output logic               sweepDone
);

  xt_pkg::walkStrobeT strobe;
  logic [IDX_W-1:0]   walkIdx;

  xt_ctrl #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameEnd  (frameEnd),
    .cancelAll (cancelAll),
    .strobe    (strobe),
    .walkIdx   (walkIdx),
    .sweepDone (sweepDone)
  );

  xt_table #(
    .ENTRIES    (ENTRIES),
    .ADDR_W     (ADDR_W),
    .TOKEN_W    (TOKEN_W),
    .AGE_W      (AGE_W),
    .AGE_RELOAD (AGE_RELOAD),
    .IDX_W      (IDX_W)
  ) table_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .walkIdx       (walkIdx),
    .frameStart    (frameStart),
    .lookupValid   (lookupValid),
    .lookupAddr    (lookupAddr),
    .lookupToken   (lookupToken),
    .lookupHit     (lookupHit),
    .lookupDone    (lookupDone),
    .lookupIdx     (lookupIdx),
    .allocValid    (allocValid),
    .allocAddr     (allocAddr),
    .allocToken    (allocToken),
    .allocOk       (allocOk),
    .allocIdx      (allocIdx),
    .completeValid (completeValid),
    .completeIdx   (completeIdx),
    .cancelValid   (cancelValid),
    .cancelIdx     (cancelIdx),
    .cancelAddr    (cancelAddr),
    .cancelToken   (cancelToken)
  );

endmodule

// File: tb/xfer_tracker_tb_top.sv
module xfer_tracker_tb_top;
  localparam int N = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, frameStart, frameEnd, cancelAll;
  logic        lookupValid, lookupHit, lookupDone;
  logic [31:0] lookupAddr, lookupToken;
  logic [2:0]  lookupIdx;
  logic        allocValid, allocOk;
  logic [31:0] allocAddr, allocToken;
  logic [2:0]  allocIdx;
  logic        completeValid;
  logic [2:0]  completeIdx;
  logic        cancelValid, sweepDone;
  logic [2:0]  cancelIdx;
  logic [31:0] cancelAddr, cancelToken;

  xfer_tracker dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .cancelAll(cancelAll), .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .lookupToken(lookupToken), .lookupHit(lookupHit), .lookupDone(lookupDone),
    .lookupIdx(lookupIdx), .allocValid(allocValid), .allocAddr(allocAddr),
    .allocToken(allocToken), .allocOk(allocOk), .allocIdx(allocIdx),
    .completeValid(completeValid), .completeIdx(completeIdx),
    .cancelValid(cancelValid), .cancelIdx(cancelIdx), .cancelAddr(cancelAddr),
    .cancelToken(cancelToken), .sweepDone(sweepDone)
  );

  localparam logic [31:0] A0 = 32'h1000_0040, A1 = 32'h1000_0080;
  localparam logic [31:0] A2 = 32'h1000_00C0, A3 = 32'h2000_0100;
  localparam logic [31:0] T0 = 32'h00E0_0169, T1 = 32'h03E8_82E1;
  localparam logic [31:0] T2 = 32'h0010_042D;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] tok;
    logic        hit;
    logic [2:0]  idx;
  } vecT;

  localparam vecT VEC [8] = '{
    '{A0, T0, 1'b1, 3'd0},
    '{A1, T1, 1'b1, 3'd1},
    '{A2, T2, 1'b1, 3'd2},
    '{A3, T0, 1'b0, 3'd0},
    '{A0 ^ 32'h10, T0, 1'b0, 3'd0},
    '{A2, T2 ^ 32'h8000_0000, 1'b0, 3'd0},
    '{A0, T0, 1'b1, 3'd0},
    '{A1, T1, 1'b1, 3'd1}
  };

  int checks = 0;
  int errors = 0;
  logic [N-1:0] seenMask;
  logic [31:0]  capAddr [N];
  logic [31:0]  capTok  [N];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nextCycle();
    @(posedge clk);
    #2;
  endtask

  task automatic idleAll();
    frameStart = 0; frameEnd = 0; cancelAll = 0;
    lookupValid = 0; lookupAddr = '0; lookupToken = '0;
    allocValid = 0; allocAddr = '0; allocToken = '0;
    completeValid = 0; completeIdx = '0;
  endtask

  task automatic doAlloc(input logic [31:0] a, input logic [31:0] t, input int expIdx, input string tag);
    allocValid = 1; allocAddr = a; allocToken = t;
    #2;
    check({tag, " allocOk"}, 64'(allocOk), 64'd1);
    check({tag, " allocIdx"}, 64'(allocIdx), 64'(expIdx));
    nextCycle();
    allocValid = 0;
  endtask

  task automatic doLookup(input logic [31:0] a, input logic [31:0] t, input logic expHit,
                          input int expIdx, input logic expDone, input string tag);
    lookupValid = 1; lookupAddr = a; lookupToken = t;
    #2;
    check({tag, " hit"}, 64'(lookupHit), 64'(expHit));
    if (expHit) check({tag, " idx"}, 64'(lookupIdx), 64'(expIdx));
    check({tag, " done"}, 64'(lookupDone), 64'(expDone));
    nextCycle();
    lookupValid = 0;
  endtask

  task automatic doComplete(input int idx);
    completeValid = 1; completeIdx = 3'(idx);
    nextCycle();
    completeValid = 0;
  endtask

  // Starts a walk (flush selects cancelAll) and watches all visit cycles.
  task automatic runWalk(input logic flush, input int endAt, input int compAt,
                         input logic [N-1:0] expMask, input string tag);
    if (flush) cancelAll = 1; else frameEnd = 1;
    nextCycle();
    cancelAll = 0; frameEnd = 0;
    seenMask = '0;
    for (int k = 0; k < N; k++) begin
      frameEnd = (k == endAt);
      completeValid = (k == compAt);
      completeIdx = 3'(k);
      #2;
      if (cancelValid) begin
        seenMask[k] = 1'b1;
        capAddr[k] = cancelAddr;
        capTok[k] = cancelToken;
        check({tag, " R6 cancelIdx"}, 64'(cancelIdx), 64'(k));
      end
      check({tag, " R6 sweepDone"}, 64'(sweepDone), 64'(k == N - 1));
      nextCycle();
      frameEnd = 0; completeValid = 0;
    end
    check({tag, " cancel mask"}, 64'(seenMask), 64'(expMask));
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idleAll();
    rstN = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    #2;
    // R1 reset state
    check("R1 allocOk", 64'(allocOk), 64'd1);
    check("R1 allocIdx", 64'(allocIdx), 64'd0);
    check("R1 cancelValid", 64'(cancelValid), 64'd0);
    check("R1 sweepDone", 64'(sweepDone), 64'd0);
    nextCycle();
    doLookup(A0, T0, 0, 0, 0, "R1 empty lookup");

    // R10 lowest free index order
    doAlloc(A0, T0, 0, "R10 a0");
    doAlloc(A1, T1, 1, "R10 a1");
    doAlloc(A2, T2, 2, "R10 a2");

    // R2 / R3 vector table walk
    for (int v = 0; v < 8; v++) begin
      doLookup(VEC[v].addr, VEC[v].tok, VEC[v].hit, int'(VEC[v].idx), 1'b0,
               VEC[v].hit ? "R2 vec" : "R3 vec");
    end

    // R3 / R6: token clash expired entry 2 only
    runWalk(0, -1, -1, 8'b0000_0100, "R3 sweep");
    check("R3 cancelAddr", 64'(capAddr[2]), 64'(A2));
    check("R3 cancelToken", 64'(capTok[2]), 64'(T2));
    doLookup(A2, T2, 0, 0, 0, "R3 gone");

    // R4 / R5 / R12: ages of entries 0 and 1 are at reload
    for (int f = 0; f < 8; f++) begin
      frameStart = 1; nextCycle(); frameStart = 0;
    end
    frameStart = 1;
    doLookup(A1, T1, 1, 1, 0, "R12 hit with frameStart");
    frameStart = 0;
    runWalk(0, -1, -1, 8'b0000_0000, "R5 nine steps");
    frameStart = 1; nextCycle(); frameStart = 0;
    runWalk(0, -1, -1, 8'b0000_0001, "R12 R4 R5 tenth step");

    // R8 / R7 completion and retirement
    doComplete(1);
    doLookup(A1, T1, 1, 1, 1, "R8 R7 done hit");
    doLookup(A1, T1, 0, 0, 0, "R7 freed");

    // R10 fill and overflow
    for (int k = 0; k < N; k++) doAlloc(32'h3000_0000 + 32'(k * 16), 32'h0100_0000 + 32'(k), k, "R10 fill");
    allocValid = 1; allocAddr = 32'h4000_0000; allocToken = 32'h55;
    #2;
    check("R10 full allocOk", 64'(allocOk), 64'd0);
    nextCycle();
    allocValid = 0;
    doLookup(32'h4000_0000, 32'h55, 0, 0, 0, "R10 no entry");
    doLookup(32'h3000_0070, 32'h0100_0007, 1, 7, 0, "R10 entry kept");

    doComplete(3);
    doLookup(32'h3000_0030, 32'h0100_0003, 1, 3, 1, "R7 retire 3");
    doAlloc(32'h3000_0030, 32'h0100_0003, 3, "R10 reuse lowest");

    // R9 / R11 / R13 flush walk with overlaps
    doComplete(4);
    runWalk(1, 2, 5, 8'b1100_1111, "R9 R11 flush");
    for (int k = 0; k < N + 2; k++) begin
      #2;
      check("R13 no second walk", 64'(sweepDone), 64'd0);
      check("R13 no cancel", 64'(cancelValid), 64'd0);
      nextCycle();
    end
    doLookup(32'h3000_0000, 32'h0100_0000, 0, 0, 0, "R9 entry0 gone");
    doLookup(32'h3000_0040, 32'h0100_0004, 0, 0, 0, "R9 entry4 gone");
    doLookup(32'h3000_0050, 32'h0100_0005, 0, 0, 0, "R11 entry5 gone");
    #2;
    check("R9 empty allocIdx", 64'(allocIdx), 64'd0);
    check("R9 empty allocOk", 64'(allocOk), 64'd1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule